// File: doc/BRIEF.md
# Random Number Generator Command and Interrupt Shell

This block is the register-facing control shell of a hardware random number generator. Software talks to it through a 32-bit register interface with one read strobe and one write strobe. Through that interface it reads a fixed identification word, issues one-shot commands, sets interrupt masks and the automatic-reseed enable, reads status and error state, and pops random words from an output FIFO.

The shell sequences two timed operations, a self test and a seed generation. When an operation ends it sets a completion flag that is separate for each operation, and it raises a level interrupt that stays high until software clears it. Two clear commands exist and they differ. The interrupt clear has no effect while an error is recorded. The error clear wipes both the error record and the completion flags. After a successful seed the FIFO is refilled from a stub word generator, and the refill stops while an error is recorded. When automatic reseeding is enabled, a new seed starts by itself after a parameterised number of served words.

The entropy source is replaced by a 32-bit LFSR. A statistical test failure can be injected through a stub input, and it is sampled when a seed operation completes.

Top module: `rng_ctrl_shell`

## Requirements
- R1: The identification word at byte offset 0x00 reads `{TYPE[3:0], 12'h000, MAJOR[7:0], MINOR[7:0]}`, which is 0x20000103 with the default parameters. Writes do not change it.
- R2: The command register at offset 0x04 is write-one-pulse. Bit 0 starts a self test, bit 1 starts a seed, bit 4 clears the interrupt and bit 5 clears the error. It always reads as zero.
- R3: A self test or seed started by a write completes OP_CYCLES clock edges after the write edge. Completion sets status bit 4 (self test) or status bit 5 (seed) at offset 0x0C, and the two flags are independent.
- R4: A start command that arrives while an operation is running is ignored, and the running operation keeps its kind.
- R5: Status bits 12:8 give the FIFO fill level, from 0 to FIFO_DEPTH (16). After the first successful seed the FIFO gains one word per clock edge until it is full.
- R6: A read of offset 0x14 with a non-zero level returns the oldest word and lowers the level by one. Returned words are never zero, and consecutive words differ. A read at level zero returns zero and leaves the level at zero.
- R7: The interrupt output equals (status bit 4 OR bit 5) AND NOT control bit 5, OR (error recorded) AND NOT control bit 6. It holds its level until it is cleared.
- R8: The interrupt clear (command bit 4) clears both completion flags only when the error register is zero. Otherwise the flags and the interrupt stay.
- R9: The error clear (command bit 5) zeroes the error register (offset 0x10) and status bit 16, and it also clears both completion flags.
- R10: A seed that completes while the stub failure input is high sets error bit 3 and status bit 16, and it still sets the seed completion flag. While an error is recorded the FIFO is not refilled. Refilling resumes on the edge after the error clear.
- R11: With control bit 4 set, the shell counts popped words. One edge after the count reaches RESEED_WORDS, a seed starts by itself and completes OP_CYCLES edges later.
- R12: The control register at offset 0x08 resets to zero and reads back bits 6:4 as written, with all other bits reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, acts on the rising edge |
| reg_rd | input | 1 | Read strobe, pops the FIFO when the address is 0x14 |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address and the current state |
| irq | output | 1 | Level interrupt |
| stub_stat_fail | input | 1 | Stub: forces a statistical failure on seed completion |

## Verification
Read data is combinational, so every register value is due in the same cycle as its address. The bench samples it 1 ns after setting the address on a falling edge. A write or pop takes effect on the next rising edge. Operation completion flags and the interrupt are due exactly OP_CYCLES edges after the write edge, and an automatic reseed completes OP_CYCLES+1 edges after the popping edge. The bench therefore counts falling edges from the return of each access task and checks that the flag is still clear one edge before it is due and set on the edge when it is due. FIFO levels are compared every cycle against a bench model in which each edge subtracts a valid pop and adds a refill when the level is below depth and refilling is allowed.

// File: rtl/rngs_pkg.sv
// Shared constants and types for the RNG command shell.
// Assumes a 32-bit register bus with byte offsets.
package rngs_pkg;
    localparam logic [7:0] OFS_ID   = 8'h00;
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_CTL  = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_ERR  = 8'h10;
    localparam logic [7:0] OFS_FIFO = 8'h14;

    localparam int CMD_TEST_BIT   = 0;
    localparam int CMD_SEED_BIT   = 1;
    localparam int CMD_CLRINT_BIT = 4;
    localparam int CMD_CLRERR_BIT = 5;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] LFSR_TAPS = 32'hA300_0000;
    localparam logic [WORD_W-1:0] LFSR_INIT = 32'h6B3D_91C5;

    // Control register fields, packed in the order of bits 6..4.
    typedef struct packed {
        logic mask_err;
        logic mask_done;
        logic auto_en;
    } ctl_t;

    typedef enum logic [1:0] {OP_NONE, OP_TEST, OP_SEED} op_e;
endpackage

// File: rtl/rngs_op_seq.sv
// Operation sequencer: runs one timed self test or seed at a time and
// counts served words to start an automatic reseed.
// Assumes OP_CYCLES >= 1 and RESEED_WORDS >= 1. Starts during busy are dropped.
module rngs_op_seq
    import rngs_pkg::*;
#(
    parameter int OP_CYCLES    = 64,
    parameter int RESEED_WORDS = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_go,
    input  logic seed_go,
    input  logic auto_en,
    input  logic word_served,
    input  logic stat_fail,
    output logic busy,
    output logic test_done,
    output logic seed_done,
    output logic seed_ok,
    output logic seed_bad
);
    localparam int CW = $clog2(OP_CYCLES + 1);
    localparam int SW = $clog2(RESEED_WORDS + 1);
    localparam logic [CW-1:0] CNT_LOAD  = CW'(OP_CYCLES - 1);
    localparam logic [SW-1:0] SRV_LIMIT = SW'(RESEED_WORDS);

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] srv_q;
    op_e           op_q;
    logic          busy_q;
    logic          auto_go;
    logic          finish;

    assign auto_go   = auto_en && (srv_q >= SRV_LIMIT) && !busy_q;
    assign finish    = busy_q && (cnt_q == '0);
    assign busy      = busy_q;
    assign test_done = finish && (op_q == OP_TEST);
    assign seed_done = finish && (op_q == OP_SEED);
    assign seed_ok   = seed_done && !stat_fail;
    assign seed_bad  = seed_done && stat_fail;

    // Start, count down and retire the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_NONE;
        end else if (!busy_q && (test_go || seed_go || auto_go)) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
            op_q   <= test_go ? OP_TEST : OP_SEED;
        end else if (finish) begin
            busy_q <= 1'b0;
            op_q   <= OP_NONE;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Count popped words while auto reseed is on; restart on each reseed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_q <= '0;
        end else if (auto_go) begin
            srv_q <= '0;
        end else if (auto_en && word_served && (srv_q < SRV_LIMIT)) begin
            srv_q <= srv_q + 1'b1;
        end
    end

    // R4: a running operation is neither restarted nor changed in kind.
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (cnt_q != '0) |=> busy_q && (op_q == $past(op_q)) && (cnt_q == $past(cnt_q) - 1'b1));
    // R3: every operation starts with the full cycle budget.
    a_r3_full_budget: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (cnt_q == CNT_LOAD));
    // R11: the served-word count never passes the reseed limit.
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        srv_q <= SRV_LIMIT);
endmodule

// File: rtl/rngs_word_fifo.sv
// Output word FIFO with a stub LFSR word source. One word is added per edge
// while refill is allowed and there is room, and one is removed per valid pop.
// Assumes DEPTH is a power of two. A read at level zero returns zero.
module rngs_word_fifo
    import rngs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              pop_req,
    output logic [WORD_W-1:0] rd_word,
    output logic [LW-1:0]     level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] lfsr_q;
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [LW-1:0]     lvl_q;
    logic              do_fill, do_pop;

    assign do_fill = fill_en && (lvl_q < FULL);
    assign do_pop  = pop_req && (lvl_q != '0);
    assign rd_word = (lvl_q != '0) ? mem[rptr_q] : '0;
    assign level   = lvl_q;

    // Advance the Galois LFSR once per stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= LFSR_INIT;
        end else if (do_fill) begin
            lfsr_q <= {1'b0, lfsr_q[WORD_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
        end
    end

    // Store the current LFSR word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_fill) begin
            mem[wptr_q] <= lfsr_q;
        end
    end

    // Move the pointers and the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (do_fill) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            lvl_q <= lvl_q + LW'(do_fill) - LW'(do_pop);
        end
    end

    // R5: the level never exceeds the depth.
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= FULL);
    // R6: a valid pop with no refill lowers the level by one.
    a_r6_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && (lvl_q != '0) && !fill_en |=> lvl_q == $past(lvl_q) - 1'b1);
    // R10: with refill stopped and no pop, the level holds.
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en && !pop_req |=> $stable(lvl_q));
endmodule

// File: rtl/rngs_irq_ctl.sv
// Completion flags, error record and interrupt output. Completion events take
// precedence over clears on the same edge. The interrupt clear is blocked while
// an error is recorded, and the error clear also drops the completion flags.
module rngs_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic test_done,
    input  logic seed_done,
    input  logic seed_bad,
    input  logic clr_int,
    input  logic clr_err,
    input  logic mask_done,
    input  logic mask_err,
    output logic test_flag,
    output logic seed_flag,
    output logic stat_err,
    output logic irq
);
    logic test_q, seed_q, err_q;

    assign test_flag = test_q;
    assign seed_flag = seed_q;
    assign stat_err  = err_q;
    assign irq = ((test_q || seed_q) && !mask_done) || (err_q && !mask_err);

    // Record a statistical failure until the error clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (seed_bad) err_q <= 1'b1;
        else if (clr_err)  err_q <= 1'b0;
    end

    // Set completion flags on events; clear on commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= 1'b0;
            seed_q <= 1'b0;
        end else if (test_done || seed_done) begin
            test_q <= test_q || test_done;
            seed_q <= seed_q || seed_done;
        end else if (clr_err || (clr_int && !err_q)) begin
            test_q <= 1'b0;
            seed_q <= 1'b0;
        end
    end

    // R8: with an error recorded, an interrupt clear leaves the flags alone.
    a_r8_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        clr_int && !clr_err && err_q && !test_done && !seed_done |=> $stable({test_q, seed_q}) && irq == $past(irq));
    // R9: the error clear empties the error record and the flags.
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err && !test_done && !seed_done |=> !err_q && !test_q && !seed_q);
    // R7: with both masks set the interrupt stays low.
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_done && mask_err |-> !irq);
endmodule

// File: rtl/rng_ctrl_shell.sv
// Top of the RNG command shell: register decode, read mux, control register
// and seeded state. Read data is combinational from the address. A FIFO read
// pops on the edge that ends the read strobe cycle.
module rng_ctrl_shell
    import rngs_pkg::*;
#(
    parameter int OP_CYCLES    = 64,
    parameter int RESEED_WORDS = 1 << 20,
    parameter int FIFO_DEPTH   = 16,
    parameter int ID_TYPE      = 2,
    parameter int ID_MAJOR     = 1,
    parameter int ID_MINOR     = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        stub_stat_fail
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);
    localparam logic [31:0] ID_WORD = {4'(ID_TYPE), 12'h000, 8'(ID_MAJOR), 8'(ID_MINOR)};

    ctl_t               ctl_q;
    logic               seeded_q;
    logic               wr_cmd, wr_ctl, rd_fifo;
    logic               test_go, seed_go, clr_int, clr_err;
    logic               busy, test_done, seed_done, seed_ok, seed_bad;
    logic               test_flag, seed_flag, stat_err;
    logic [WORD_W-1:0]  fifo_word;
    logic [LW-1:0]      fifo_level;
    logic               word_served;
    logic               unused_bits;

    assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
    assign wr_ctl  = reg_wr && (reg_addr == OFS_CTL);
    assign rd_fifo = reg_rd && (reg_addr == OFS_FIFO);
    assign test_go = wr_cmd && reg_wdata[CMD_TEST_BIT];
    assign seed_go = wr_cmd && reg_wdata[CMD_SEED_BIT];
    assign clr_int = wr_cmd && reg_wdata[CMD_CLRINT_BIT];
    assign clr_err = wr_cmd && reg_wdata[CMD_CLRERR_BIT];
    assign word_served = rd_fifo && (fifo_level != '0);
    assign unused_bits = ^{reg_wdata[31:7], reg_wdata[3:2], busy};

    // Hold the control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= reg_wdata[6:4];
    end

    // Remember that at least one seed has succeeded.
    always_ff @(posedge clk) begin
        if (!rst_n)       seeded_q <= 1'b0;
        else if (seed_ok) seeded_q <= 1'b1;
    end

    rngs_op_seq #(.OP_CYCLES(OP_CYCLES), .RESEED_WORDS(RESEED_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .test_go(test_go), .seed_go(seed_go),
        .auto_en(ctl_q.auto_en), .word_served(word_served), .stat_fail(stub_stat_fail),
        .busy(busy), .test_done(test_done), .seed_done(seed_done),
        .seed_ok(seed_ok), .seed_bad(seed_bad)
    );

    rngs_word_fifo #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .fill_en(seeded_q && !stat_err),
        .pop_req(rd_fifo), .rd_word(fifo_word), .level(fifo_level)
    );

    rngs_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .test_done(test_done), .seed_done(seed_done),
        .seed_bad(seed_bad), .clr_int(clr_int), .clr_err(clr_err),
        .mask_done(ctl_q.mask_done), .mask_err(ctl_q.mask_err),
        .test_flag(test_flag), .seed_flag(seed_flag), .stat_err(stat_err), .irq(irq)
    );

    // Select the read data for the addressed register.
    always_comb begin
        case (reg_addr)
            OFS_ID:   reg_rdata = ID_WORD;
            OFS_CTL:  reg_rdata = {25'd0, ctl_q, 4'd0};
            OFS_STAT: reg_rdata = {15'd0, stat_err, 8'(fifo_level), 2'd0, seed_flag, test_flag, 4'd0};
            OFS_ERR:  reg_rdata = {28'd0, stat_err, 3'd0};
            OFS_FIFO: reg_rdata = fifo_word;
            default:  reg_rdata = 32'd0;
        endcase
    end

    // R2: the command register never reads back a set bit.
    a_r2_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CMD) |-> (reg_rdata == 32'd0));
    // R10: a failed seed does not mark the generator as seeded.
    a_r10_no_seed_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        seed_bad && !seeded_q |=> !seeded_q);
endmodule

// File: tb/rng_ctrl_shell_test.sv
// Bench for rng_ctrl_shell: directed corner cases plus random FIFO pops
// checked against a bench level model.
module rng_ctrl_shell_test;
    localparam int N   = 16;
    localparam int RSW = 8;
    localparam int DEP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        stub_stat_fail = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int model_lvl = 0;
    logic [31:0] prev_word = 32'd0;

    always #5 clk = ~clk;

    rng_ctrl_shell #(.OP_CYCLES(N), .RESEED_WORDS(RSW), .FIFO_DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .stub_stat_fail(stub_stat_fail)
    );

    function automatic logic [31:0] stat_exp(bit st, bit sd, bit er, int lvl);
        return {15'd0, er, 8'(lvl), 2'd0, sd, st, 4'd0};
    endfunction

    function automatic logic [31:0] ctl_exp(bit merr, bit mdone, bit auto_on);
        return {25'd0, merr, mdone, auto_on, 4'd0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Random pops for a number of cycles against the level model.
    task automatic rand_pops(input bit fill_on, input int cycles, input int pct);
        logic [31:0] v;
        for (int i = 0; i < cycles; i++) begin
            bit pop;
            @(negedge clk);
            reg_rd = 1'b0;
            peek(8'h0C, v);
            check("R5 level model", 32'(v[12:8]), 32'(model_lvl));
            pop = (($urandom % 100) < pct);
            if (pop) begin
                reg_addr = 8'h14;
                reg_rd = 1'b1;
                #1;
                if (model_lvl > 0) begin
                    check("R6 word nonzero", 32'(reg_rdata != 0), 32'd1);
                    check("R6 word differs", 32'(reg_rdata != prev_word), 32'd1);
                    prev_word = reg_rdata;
                end else begin
                    check("R6 empty read zero", reg_rdata, 32'd0);
                end
            end
            model_lvl = model_lvl - ((pop && model_lvl > 0) ? 1 : 0);
            if (fill_on && (model_lvl + ((pop && model_lvl >= 0) ? 0 : 0)) >= 0) begin
                // refill decision uses the level before the pop
            end
            model_lvl = model_lvl + ((fill_on && (model_lvl + ((pop && model_lvl >= 0) ? 0 : 0)) < DEP
                         && ((model_lvl + (pop ? 1 : 0)) < DEP || !pop)) ? 1 : 0);
        end
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7));
        step(3);
        rst_n = 1'b1;
        step(1);

        // Reset state.
        peek(8'h00, v); check("R1 id word", v, 32'h2000_0103);
        peek(8'h08, v); check("R12 control reset", v, 32'd0);
        peek(8'h0C, v); check("R5 status reset", v, 32'd0);
        peek(8'h10, v); check("R9 error reset", v, 32'd0);
        check("R7 irq reset", 32'(irq), 32'd0);
        wr(8'h00, 32'hFFFF_FFFF);
        peek(8'h00, v); check("R1 id after write", v, 32'h2000_0103);

        // Command readback.
        wr(8'h04, 32'h0000_0030);
        peek(8'h04, v); check("R2 command reads zero", v, 32'd0);

        // Self test timing.
        wr(8'h04, 32'h1);
        peek(8'h04, v); check("R2 command reads zero while busy", v, 32'd0);
        step(N - 1);
        peek(8'h0C, v); check("R3 test not early", v, stat_exp(0, 0, 0, 0));
        step(1);
        peek(8'h0C, v); check("R3 test done flag", v, stat_exp(1, 0, 0, 0));
        check("R7 irq on done", 32'(irq), 32'd1);
        wr(8'h04, 32'h10);
        peek(8'h0C, v); check("R8 clear int", v, stat_exp(0, 0, 0, 0));
        check("R8 irq cleared", 32'(irq), 32'd0);

        // Done mask.
        wr(8'h08, 32'h0000_0020);
        peek(8'h08, v); check("R12 control readback", v, ctl_exp(0, 1, 0));
        wr(8'h04, 32'h1);
        step(N);
        peek(8'h0C, v); check("R7 flag under mask", v, stat_exp(1, 0, 0, 0));
        check("R7 irq masked", 32'(irq), 32'd0);
        wr(8'h08, 32'hFFFF_FF8F);
        peek(8'h08, v); check("R12 control other bits", v, 32'd0);
        check("R7 irq unmasked", 32'(irq), 32'd1);
        wr(8'h04, 32'h10);

        // Start during busy is ignored.
        wr(8'h04, 32'h1);
        wr(8'h04, 32'h2);
        step(N);
        peek(8'h0C, v); check("R4 busy start dropped", v, stat_exp(1, 0, 0, 0));
        step(N);
        peek(8'h0C, v); check("R4 no late seed", v, stat_exp(1, 0, 0, 0));
        wr(8'h04, 32'h10);

        // Empty read before seeding.
        rd(8'h14, v); check("R6 empty read", v, 32'd0);
        peek(8'h0C, v); check("R6 level stays zero", v, 32'd0);

        // Seed and fill.
        wr(8'h04, 32'h2);
        step(N - 1);
        peek(8'h0C, v); check("R3 seed not early", v, stat_exp(0, 0, 0, 0));
        step(1);
        peek(8'h0C, v); check("R3 seed done flag", v, stat_exp(0, 1, 0, 0));
        step(1);
        peek(8'h0C, v); check("R5 first word", v, stat_exp(0, 1, 0, 1));
        step(DEP - 1);
        peek(8'h0C, v); check("R5 full", v, stat_exp(0, 1, 0, DEP));
        step(3);
        peek(8'h0C, v); check("R5 capped", v, stat_exp(0, 1, 0, DEP));
        wr(8'h04, 32'h10);

        // Random pops with refill.
        model_lvl = DEP;
        rand_pops(1'b1, 300, 60);
        step(DEP + 4);
        model_lvl = DEP;

        // Statistical failure.
        stub_stat_fail = 1'b1;
        wr(8'h04, 32'h2);
        step(N);
        stub_stat_fail = 1'b0;
        peek(8'h10, v); check("R10 error bit 3", v, 32'h8);
        peek(8'h0C, v); check("R10 status error", v, stat_exp(0, 1, 1, DEP));
        check("R7 irq on error", 32'(irq), 32'd1);
        wr(8'h04, 32'h10);
        peek(8'h0C, v); check("R8 blocked clear", v, stat_exp(0, 1, 1, DEP));
        check("R8 irq kept", 32'(irq), 32'd1);
        model_lvl = DEP;
        rand_pops(1'b0, 80, 50);
        step(1);
        peek(8'h0C, v); check("R10 frozen empty", v, stat_exp(0, 1, 1, model_lvl));
        wr(8'h08, 32'h20);
        check("R7 error irq unmasked", 32'(irq), 32'd1);
        wr(8'h08, 32'h60);
        check("R7 both masked", 32'(irq), 32'd0);
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h20);
        peek(8'h10, v); check("R9 error cleared", v, 32'd0);
        peek(8'h0C, v); check("R9 flags cleared", v, stat_exp(0, 0, 0, model_lvl));
        check("R9 irq cleared", 32'(irq), 32'd0);
        step(1);
        peek(8'h0C, v); check("R10 refill resumes", v, stat_exp(0, 0, 0, model_lvl + 1));
        step(DEP + 2);

        // Automatic reseed.
        wr(8'h08, 32'h10);
        for (int k = 0; k < RSW; k++) begin
            rd(8'h14, v);
            check("R11 served word", 32'(v != 0), 32'd1);
        end
        step(N);
        peek(8'h0C, v); check("R11 reseed not early", 32'(v[5]), 32'd0);
        step(1);
        peek(8'h0C, v); check("R11 reseed done", 32'(v[5]), 32'd1);
        check("R11 irq on reseed", 32'(irq), 32'd1);
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h10);
        check("R8 final clear", 32'(irq), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule